// File: doc/BRIEF.md
# CCD Horizontal Pixel Clock and CDS Strobe Generator

This block drives the horizontal side of an interline CCD readout. While a readout window input is held high, it divides a fast system clock into pixel periods. In each period it drives a two-phase complementary horizontal clock pair and a reset-gate pulse that starts with the second phase. It also issues single-cycle clamp and sample strobes, which an external correlated double sampler uses to take the reset reference and then the signal level of the same pixel.

Each line is 791 pixel counts long. Counts 1 to 9 are empty register stages, 10 to 777 are the 768 photoactive pixels, 778 to 789 are the 12 light-shielded reference pixels, and 790 and 791 trail. Two qualifiers travel with the sample strobe. One marks image pixels for the capture path and the other marks shielded pixels for black-level averaging. The clamp and sample offsets are inputs in fast-clock cycles and are expected to be stable while the window is open.

Top module: `ccd_hclk_gen`

## Requirements
- R1: In reset, and from the second clock edge after `rd_win` is sampled low, the outputs rest at h1=1, h2=0, rg=0, with clamp, sample, pix_valid and dark_valid all 0.
- R2: After `rd_win` is sampled high, the outputs show phase 0 of count 1 from the second clock edge onward. A pixel lasts PIX_DIV cycles. h2 is 1 during phases 0 to PIX_DIV/2-1 and h1 is always the complement of h2.
- R3: rg is 1 during phases 0 to RST_CYC-1 of every pixel, so it rises in the same cycle as h2 and lasts RST_CYC cycles.
- R4: clamp is a one-cycle pulse in the phase equal to `clamp_ofs`, once per pixel.
- R5: sample is a one-cycle pulse in the phase equal to `sample_ofs`, once per pixel.
- R6: pix_valid is 1 only together with sample, and only for counts 10 to 777.
- R7: dark_valid is 1 only together with sample, and only for counts 778 to 789. It is never 1 together with pix_valid.
- R8: Counts 1 to 9, 790 and 791 raise neither qualifier, although clocks and strobes keep running during them.
- R9: While the window stays high, count 791 is followed directly by count 1 of the next line, phase 0.
- R10: When the window closes in the middle of a line, the next window starts again at count 1, phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock, PIX_DIV cycles per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_win | input | 1 | Horizontal readout window |
| clamp_ofs | input | OFS_W | Clamp strobe phase within a pixel |
| sample_ofs | input | OFS_W | Sample strobe phase within a pixel |
| h1 | output | 1 | Horizontal clock, phase 1 |
| h2 | output | 1 | Horizontal clock, phase 2 |
| rg | output | 1 | Reset-gate pulse |
| clamp | output | 1 | Reference-level strobe |
| sample | output | 1 | Signal-level strobe |
| pix_valid | output | 1 | Sample belongs to a photoactive pixel |
| dark_valid | output | 1 | Sample belongs to a shielded reference pixel |

## Verification
The bench sweeps all 64 pairs of clamp and sample offsets. Each pair gets a short window that it compares cycle by cycle, so a strobe one phase early or late, a strobe that lasts two cycles, or a reset pulse that is not aligned with h2 shows up at once. Two full lines and part of a third run back to back, which checks the zone boundaries at counts 9/10, 777/778 and 789/790 and the wrap after 791. Errors here would show as a qualifier on the wrong pixel or as a 792nd count. Windows closed in mid-line catch a design that keeps its count instead of restarting, or that does not return to the idle levels on the second edge.

// File: rtl/hclk_pkg.sv
// Shared types for the horizontal pixel clock generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package hclk_pkg;

    // Classification of one horizontal count within a line
    typedef enum logic [1:0] {
        PX_EMPTY  = 2'd0,
        PX_ACTIVE = 2'd1,
        PX_DARK   = 2'd2,
        PX_TRAIL  = 2'd3
    } px_kind_t;

endpackage

// File: rtl/hpix_timer.sv
// Pixel phase and line count timer.
// Counts fast-clock phases within a pixel and pixel counts (1-based) within a line.
// Assumes DIV >= 2. The window is sampled every cycle, and a closed window
// returns the timer to phase 0 of count 1.
module hpix_timer #(
    parameter int DIV      = 8,
    parameter int LINE_LEN = 791,
    localparam int PH_W    = (DIV > 1) ? $clog2(DIV) : 1,
    localparam int CNT_W   = $clog2(LINE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win,
    output logic             run,
    output logic [PH_W-1:0]  ph,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(DIV - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_LEN);

    // Advance phase and count while the window is open, rewind otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !win) begin
            run <= 1'b0;
            ph  <= '0;
            cnt <= CNT_W'(1);
        end else begin
            run <= 1'b1;
            if (run) begin
                if (ph == PH_LAST) begin
                    ph  <= '0;
                    cnt <= (cnt == CNT_LAST) ? CNT_W'(1) : cnt + CNT_W'(1);
                end else begin
                    ph <= ph + PH_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/hpix_classify.sv
// Line layout decoder: maps a 1-based pixel count to its zone
// (empty stages, photoactive, shielded reference, trailing).
// Purely combinational; assumes counts start at 1.
module hpix_classify
    import hclk_pkg::*;
#(
    parameter int N_EMPTY  = 9,
    parameter int N_ACTIVE = 768,
    parameter int N_DARK   = 12,
    parameter int CNT_W    = 10
) (
    input  logic [CNT_W-1:0] cnt,
    output px_kind_t         kind
);
    localparam logic [CNT_W-1:0] ACT_FIRST = CNT_W'(N_EMPTY + 1);
    localparam logic [CNT_W-1:0] ACT_LAST  = CNT_W'(N_EMPTY + N_ACTIVE);
    localparam logic [CNT_W-1:0] DARK_LAST = CNT_W'(N_EMPTY + N_ACTIVE + N_DARK);

    // Zone lookup by range comparison
    always_comb begin
        if (cnt < ACT_FIRST)       kind = PX_EMPTY;
        else if (cnt <= ACT_LAST)  kind = PX_ACTIVE;
        else if (cnt <= DARK_LAST) kind = PX_DARK;
        else                       kind = PX_TRAIL;
    end
endmodule

// File: rtl/hpix_wave.sv
// Waveform decoder with registered outputs.
// Turns phase, zone and run state into the clock pair, reset gate, CDS strobes
// and qualifiers. Assumes RST_W <= DIV/2, so the reset gate stays inside h2 high.
// Idle levels: h1 high, everything else low.
module hpix_wave
    import hclk_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int RST_W = 2,
    parameter int PH_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PH_W-1:0] ph,
    input  px_kind_t        kind,
    input  logic [PH_W-1:0] clamp_ofs,
    input  logic [PH_W-1:0] sample_ofs,
    output logic            h1,
    output logic            h2,
    output logic            rg,
    output logic            clamp,
    output logic            sample,
    output logic            pix_valid,
    output logic            dark_valid
);
    localparam logic [PH_W-1:0] HALF  = PH_W'(DIV / 2);
    localparam logic [PH_W-1:0] RG_END = PH_W'(RST_W);

    logic h2_d, rg_d, cl_d, sm_d;

    // Next-cycle levels decoded from the current phase
    always_comb begin
        h2_d = run && (ph < HALF);
        rg_d = run && (ph < RG_END);
        cl_d = run && (ph == clamp_ofs);
        sm_d = run && (ph == sample_ofs);
    end

    // Output registers so the sensor-facing lines change only at clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1         <= 1'b1;
            h2         <= 1'b0;
            rg         <= 1'b0;
            clamp      <= 1'b0;
            sample     <= 1'b0;
            pix_valid  <= 1'b0;
            dark_valid <= 1'b0;
        end else begin
            h1         <= !h2_d;
            h2         <= h2_d;
            rg         <= rg_d;
            clamp      <= cl_d;
            sample     <= sm_d;
            pix_valid  <= sm_d && (kind == PX_ACTIVE);
            dark_valid <= sm_d && (kind == PX_DARK);
        end
    end
endmodule

// File: rtl/ccd_hclk_gen.sv
// Top level of the CCD horizontal pixel clock and CDS strobe generator.
// One pixel is PIX_DIV fast cycles. A line is N_EMPTY + N_ACTIVE + N_DARK + N_TRAIL counts.
// Assumes offsets are stable while rd_win is high and RST_CYC <= PIX_DIV/2.
module ccd_hclk_gen
    import hclk_pkg::*;
#(
    parameter int PIX_DIV  = 8,
    parameter int RST_CYC  = 2,
    parameter int N_EMPTY  = 9,
    parameter int N_ACTIVE = 768,
    parameter int N_DARK   = 12,
    parameter int N_TRAIL  = 2,
    localparam int OFS_W   = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1,
    localparam int LINE_LEN = N_EMPTY + N_ACTIVE + N_DARK + N_TRAIL,
    localparam int CNT_W   = $clog2(LINE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_win,
    input  logic [OFS_W-1:0] clamp_ofs,
    input  logic [OFS_W-1:0] sample_ofs,
    output logic             h1,
    output logic             h2,
    output logic             rg,
    output logic             clamp,
    output logic             sample,
    output logic             pix_valid,
    output logic             dark_valid
);
    logic             run;
    logic [OFS_W-1:0] ph;
    logic [CNT_W-1:0] cnt;
    px_kind_t         kind;

    hpix_timer #(.DIV(PIX_DIV), .LINE_LEN(LINE_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .win(rd_win),
        .run(run), .ph(ph), .cnt(cnt)
    );

    hpix_classify #(
        .N_EMPTY(N_EMPTY), .N_ACTIVE(N_ACTIVE), .N_DARK(N_DARK), .CNT_W(CNT_W)
    ) u_class (
        .cnt(cnt), .kind(kind)
    );

    hpix_wave #(.DIV(PIX_DIV), .RST_W(RST_CYC), .PH_W(OFS_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .run(run), .ph(ph), .kind(kind),
        .clamp_ofs(clamp_ofs), .sample_ofs(sample_ofs),
        .h1(h1), .h2(h2), .rg(rg), .clamp(clamp), .sample(sample),
        .pix_valid(pix_valid), .dark_valid(dark_valid)
    );
endmodule

// File: rtl/hclk_chk.sv
// Port-level property checker for ccd_hclk_gen, attached by bind.
// Assumes PIX_DIV >= 2 and RST_CYC <= PIX_DIV/2.
module hclk_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_win,
    input logic h1,
    input logic h2,
    input logic rg,
    input logic clamp,
    input logic sample,
    input logic pix_valid,
    input logic dark_valid
);
    assert_idle_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_win, 2) |-> (h1 && !h2 && !rg && !clamp && !sample && !pix_valid && !dark_valid));

    assert_clock_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        h1 != h2);

    assert_rg_with_h2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2) |-> rg);

    assert_rg_inside_h2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rg |-> h2);

    assert_clamp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clamp |=> !clamp);

    assert_sample_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

    assert_pix_with_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> sample);

    assert_dark_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dark_valid |-> (sample && !pix_valid));
endmodule

bind ccd_hclk_gen hclk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_win(rd_win),
    .h1(h1), .h2(h2), .rg(rg), .clamp(clamp), .sample(sample),
    .pix_valid(pix_valid), .dark_valid(dark_valid)
);

// File: tb/sim_ccd_hclk_gen.sv
// Self-checking bench: offset sweep, full-line layout with wrap, mid-line restart.
module sim_ccd_hclk_gen;
    localparam int CLK_P = 10;
    localparam int DIV   = 8;
    localparam int RSTC  = 2;
    localparam int LINE  = 791;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_win = 1'b0;
    logic [2:0] clamp_ofs = '0;
    logic [2:0] sample_ofs = '0;
    logic h1, h2, rg, clamp, sample, pix_valid, dark_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    ccd_hclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .rd_win(rd_win),
        .clamp_ofs(clamp_ofs), .sample_ofs(sample_ofs),
        .h1(h1), .h2(h2), .rg(rg), .clamp(clamp), .sample(sample),
        .pix_valid(pix_valid), .dark_valid(dark_valid)
    );

    localparam logic [6:0] IDLE = 7'b1000000;

    // Expected {h1,h2,rg,clamp,sample,pix_valid,dark_valid} for running index i
    function automatic logic [6:0] exp_vec(int i, int co, int so);
        int p = i % DIV;
        int c = (i / DIV) % LINE + 1;
        logic hh = (p < DIV/2);
        logic s  = (p == so);
        return {!hh, hh, (p < RSTC), (p == co), s,
                s && (c >= 10) && (c <= 777), s && (c >= 778) && (c <= 789)};
    endfunction

    // Compare outputs; choose the requirement tag from the first mismatching field
    task automatic check(logic [6:0] e, int i, string ctx);
        logic [6:0] a = {h1, h2, rg, clamp, sample, pix_valid, dark_valid};
        string tag;
        int c = (i / DIV) % LINE + 1;
        checks++;
        if (a !== e) begin
            errors++;
            if (e == IDLE && i < 0)                 tag = ctx;
            else if (a[6:5] !== e[6:5])             tag = "R2";
            else if (a[4] !== e[4])                 tag = "R3";
            else if (a[3] !== e[3])                 tag = "R4";
            else if (a[2] !== e[2])                 tag = "R5";
            else if (i >= LINE*DIV)                 tag = "R9";
            else if (c <= 9 || c >= 790)            tag = "R8";
            else if (a[1] !== e[1])                 tag = "R6";
            else                                    tag = "R7";
            $display("FAIL %s (%s) idx=%0d actual=%b expected=%b", tag, ctx, i, a, e);
        end
    endtask

    // Open a window for n edges, check every cycle, close it and check the idle return
    task automatic run_window(int n, int co, int so, string ctx);
        clamp_ofs  = 3'(co);
        sample_ofs = 3'(so);
        rd_win = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == 1) check(IDLE, -1, "R1");
            else        check(exp_vec(k-2, co, so), k-2, ctx);
        end
        rd_win = 1'b0;
        @(negedge clk);
        check(exp_vec(n-1, co, so), n-1, ctx);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(IDLE, -1, "R10");
        end
    endtask

    initial begin
        // R1: idle levels during reset
        repeat (3) @(negedge clk);
        check(IDLE, -1, "R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(IDLE, -1, "R1");

        // R4, R5, R2, R3: every clamp/sample offset pair over a few pixels
        for (int co = 0; co < DIV; co++)
            for (int so = 0; so < DIV; so++)
                run_window(2 + 3*DIV, co, so, "R4");

        // R6, R7, R8, R9: two full lines plus part of a third
        run_window(2 + 2*LINE*DIV + 20*DIV, 3, 6, "R9");

        // R10: close in mid-line, then restart must begin at count 1
        run_window(2 + 150*DIV + 3, 2, 5, "R10");
        run_window(2 + 15*DIV, 2, 5, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule